// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block produces the bus cycles that a small 8-bit processor core runs when it takes a maskable interrupt, a non-maskable interrupt or a reset. All three events share one six-cycle sequence. The first cycle is a dummy read at the current program counter. The next three cycles access a stack held in page one: the program counter high byte, then the low byte, then the status byte. The last two cycles read a two-byte vector, low byte first. The core passes in its stack pointer, program counter and status. When the sequence ends, the block returns the new values of all three.

On a reset, a flag is latched when the sequence starts and held until it ends. While that flag is set, the read/write strobe is forced to read. The three stack cycles still put their decrementing addresses on the bus, and the stack pointer still drops by three, but memory is not written. The parameter `RESET_WRITES` selects a variant without this gating, in which a reset writes the three bytes exactly as an interrupt does.

Top module: `irq_entry_seq`

## Requirements
- R1: When several requests are seen in the same idle cycle, reset wins over non-maskable interrupt, and non-maskable interrupt wins over maskable interrupt. The vector read pair is 0xFFFC/0xFFFD for reset, 0xFFFA/0xFFFB for non-maskable interrupt and 0xFFFE/0xFFFF for maskable interrupt.
- R2: A request seen on an idle clock edge starts six bus cycles. Cycle 0 is a read at the captured program counter. Cycles 1 to 3 are the stack cycles. Cycle 4 reads the low vector byte and cycle 5 reads the high vector byte.
- R3: The stack cycles put 0x0100 + SP, 0x0100 + SP-1 and 0x0100 + SP-2 on the address bus, wrapping modulo 256 inside page one. SP is the stack pointer captured at the start.
- R4: On the three stack cycles, `wr_data` carries the program counter high byte, then the program counter low byte, then the captured status byte.
- R5: For both interrupts, the three stack cycles are writes (`rw` = 0). Every other cycle is a read (`rw` = 1).
- R6: With `RESET_WRITES` = 0, a reset drives `rw` = 1 on all six cycles, including the stack cycles.
- R7: With `RESET_WRITES` = 1, a reset writes on the three stack cycles, exactly as an interrupt does.
- R8: `done` is high for exactly one cycle, the cycle after cycle 5. In that cycle `pc_out` = {high vector byte, low vector byte} and `sp_out` = SP - 3 (mod 256).
- R9: In the `done` cycle, `psr_out` equals the captured status with bit 2 (interrupt disable) set.
- R10: Requests that arrive while a sequence is running are ignored. That sequence is unchanged, and once it finishes the block stays idle (`busy` = 0).
- R11: After the synchronous reset `rst`, the block is idle: `busy` = 0, `done` = 0 and `rw` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| req_reset | input | 1 | Reset entry request |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_irq | input | 1 | Maskable interrupt request |
| sp_in | input | 8 | Stack pointer, captured at start |
| pc_in | input | 16 | Program counter, captured at start |
| psr_in | input | 8 | Status byte, captured at start |
| rd_data | input | 8 | Read data returned for the current bus cycle |
| addr | output | 16 | Bus address |
| wr_data | output | 8 | Bus write data |
| rw | output | 1 | 1 = read, 0 = write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 8 | Stack pointer after the sequence |
| pc_out | output | 16 | Program counter loaded from the vector |
| psr_out | output | 8 | Status with interrupt disable set |

## Verification
Two functions can land on the same edge. One is arbitration: a reset request and one or both interrupt requests can arrive in the same idle cycle. The other is the reset write gate: the reset flag and the write strobe of a stack cycle meet in the same cycle. The bench provokes the first with directed and random request combinations. It judges the winner by the vector address in cycles 4 and 5, and by whether the stack cycles write. A second instance built with `RESET_WRITES` = 1 runs on the same stimulus, so the two variants can be compared for the same reset. Late requests injected in the middle of a sequence test that arbitration is blocked while the block is busy.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DUMMY, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P, ST_VEC_L, ST_VEC_H
  } step_t;

  typedef enum logic [1:0] {EV_NONE, EV_IRQ, EV_NMI, EV_RST} event_t;

  function automatic logic is_push(step_t s);
    return (s == ST_PUSH_H) || (s == ST_PUSH_L) || (s == ST_PUSH_P);
  endfunction
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import irqseq_pkg::*;
(
  input  logic   req_reset,
  input  logic   req_nmi,
  input  logic   req_irq,
  output event_t winner
);
  always_comb begin
    if (req_reset)    winner = EV_RST;
    else if (req_nmi) winner = EV_NMI;
    else if (req_irq) winner = EV_IRQ;
    else              winner = EV_NONE;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import irqseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output step_t step
);
  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else begin
      unique case (step)
        ST_IDLE:   step <= start ? ST_DUMMY : ST_IDLE;
        ST_DUMMY:  step <= ST_PUSH_H;
        ST_PUSH_H: step <= ST_PUSH_L;
        ST_PUSH_L: step <= ST_PUSH_P;
        ST_PUSH_P: step <= ST_VEC_L;
        ST_VEC_L:  step <= ST_VEC_H;
        ST_VEC_H:  step <= ST_IDLE;
        default:   step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux
  import irqseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STACK_PAGE   = 1,
  parameter bit RESET_WRITES = 1'b0,
  localparam int ADDR_W      = 2 * DATA_W
) (
  input  step_t             step,
  input  event_t            kind,
  input  logic              rst_lat,
  input  logic [DATA_W-1:0] sp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] psr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rw
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] PAGE = DATA_W'(STACK_PAGE);

  logic [ADDR_W-1:0] vec_base;
  logic              gate_rd;

  always_comb begin
    unique case (kind)
      EV_RST:  vec_base = TOP - ADDR_W'(3);
      EV_NMI:  vec_base = TOP - ADDR_W'(5);
      default: vec_base = TOP - ADDR_W'(1);
    endcase
  end

  generate
    if (RESET_WRITES) begin : g_wr_variant
      assign gate_rd = 1'b0;
    end else begin : g_rd_variant
      assign gate_rd = rst_lat;
    end
  endgenerate

  always_comb begin
    addr    = pc;
    wr_data = '0;
    rw      = 1'b1;
    unique case (step)
      ST_DUMMY:  addr = pc;
      ST_PUSH_H: begin addr = {PAGE, sp}; wr_data = pc[ADDR_W-1:DATA_W]; end
      ST_PUSH_L: begin addr = {PAGE, sp}; wr_data = pc[DATA_W-1:0]; end
      ST_PUSH_P: begin addr = {PAGE, sp}; wr_data = psr; end
      ST_VEC_L:  addr = vec_base;
      ST_VEC_H:  addr = vec_base + ADDR_W'(1);
      default:   addr = pc;
    endcase
    if (is_push(step) && !gate_rd) rw = 1'b0;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STACK_PAGE   = 1,
  parameter int IFLAG_BIT    = 2,
  parameter bit RESET_WRITES = 1'b0,
  localparam int ADDR_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_nmi,
  input  logic              req_irq,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rw,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sp_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] psr_out
);
  localparam logic [DATA_W-1:0] IFLAG_MASK = DATA_W'(1) << IFLAG_BIT;

  event_t            winner, kind_r;
  step_t             step;
  logic              start, rst_lat;
  logic [DATA_W-1:0] sp_r, psr_r, vec_lo;
  logic [ADDR_W-1:0] pc_r;

  evt_arbiter u_arb (
    .req_reset(req_reset), .req_nmi(req_nmi), .req_irq(req_irq), .winner(winner)
  );

  assign start = (step == ST_IDLE) && (winner != EV_NONE);
  assign busy  = (step != ST_IDLE);

  seq_fsm u_fsm (.clk(clk), .rst(rst), .start(start), .step(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_r  <= EV_NONE;
      rst_lat <= 1'b0;
      sp_r    <= '0;
      pc_r    <= '0;
      psr_r   <= '0;
      vec_lo  <= '0;
      done    <= 1'b0;
      sp_out  <= '0;
      pc_out  <= '0;
      psr_out <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        kind_r  <= winner;
        rst_lat <= (winner == EV_RST);
        sp_r    <= sp_in;
        pc_r    <= pc_in;
        psr_r   <= psr_in;
      end
      if (is_push(step)) sp_r <= sp_r - DATA_W'(1);
      if (step == ST_VEC_L) vec_lo <= rd_data;
      if (step == ST_VEC_H) begin
        pc_out  <= {rd_data, vec_lo};
        sp_out  <= sp_r;
        psr_out <= psr_r | IFLAG_MASK;
        done    <= 1'b1;
        rst_lat <= 1'b0;
      end
    end
  end

  bus_mux #(
    .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .RESET_WRITES(RESET_WRITES)
  ) u_bus (
    .step(step), .kind(kind_r), .rst_lat(rst_lat), .sp(sp_r), .pc(pc_r),
    .psr(psr_r), .addr(addr), .wr_data(wr_data), .rw(rw)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irqseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STACK_PAGE   = 1,
  parameter int IFLAG_BIT    = 2,
  parameter bit RESET_WRITES = 1'b0,
  localparam int ADDR_W      = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input step_t             step,
  input logic              rst_lat,
  input logic [ADDR_W-1:0] addr,
  input logic              rw,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] psr_out
);
  a_r6_reset_reads: assert property (@(posedge clk) disable iff (rst)
    (!RESET_WRITES && rst_lat) |-> rw);

  a_r3_stack_page: assert property (@(posedge clk) disable iff (rst)
    is_push(step) |-> (addr[ADDR_W-1:DATA_W] == DATA_W'(STACK_PAGE)));

  a_r3_sp_step: assert property (@(posedge clk) disable iff (rst)
    (step == ST_PUSH_L || step == ST_PUSH_P) |->
      (addr[DATA_W-1:0] == DATA_W'($past(addr[DATA_W-1:0]) - 1'b1)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_iflag: assert property (@(posedge clk) disable iff (rst)
    done |-> psr_out[IFLAG_BIT]);

  a_r5_idle_reads: assert property (@(posedge clk) disable iff (rst)
    !busy |-> rw);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .IFLAG_BIT(IFLAG_BIT),
  .RESET_WRITES(RESET_WRITES)
) u_chk (
  .clk(clk), .rst(rst), .step(step), .rst_lat(rst_lat), .addr(addr),
  .rw(rw), .busy(busy), .done(done), .psr_out(psr_out)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_reset = 0, req_nmi = 0, req_irq = 0;
  logic [7:0]  sp_in = 0, psr_in = 0;
  logic [15:0] pc_in = 0;
  logic [7:0]  vtab [6];

  logic [15:0] addr_a, addr_b, pc_out_a, pc_out_b;
  logic [7:0]  wd_a, wd_b, rd_a, rd_b, sp_out_a, sp_out_b, psr_out_a, psr_out_b;
  logic        rw_a, rw_b, busy_a, busy_b, done_a, done_b;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem(logic [15:0] a);
    if (a >= 16'hFFFA) return vtab[a - 16'hFFFA];
    return a[7:0] ^ 8'hA5;
  endfunction

  assign rd_a = mem(addr_a);
  assign rd_b = mem(addr_b);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
    .req_irq(req_irq), .sp_in(sp_in), .pc_in(pc_in), .psr_in(psr_in),
    .rd_data(rd_a), .addr(addr_a), .wr_data(wd_a), .rw(rw_a), .busy(busy_a),
    .done(done_a), .sp_out(sp_out_a), .pc_out(pc_out_a), .psr_out(psr_out_a)
  );

  irq_entry_seq #(.RESET_WRITES(1'b1)) i_irq_entry_seq_wr (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
    .req_irq(req_irq), .sp_in(sp_in), .pc_in(pc_in), .psr_in(psr_in),
    .rd_data(rd_b), .addr(addr_b), .wr_data(wd_b), .rw(rw_b), .busy(busy_b),
    .done(done_b), .sp_out(sp_out_b), .pc_out(pc_out_b), .psr_out(psr_out_b)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 3 reset, 2 nmi, 1 irq
  function automatic int winner(logic r, logic n, logic i);
    if (r) return 3;
    if (n) return 2;
    return 1;
  endfunction

  function automatic logic [15:0] vec_base(int k);
    if (k == 3) return 16'hFFFC;
    if (k == 2) return 16'hFFFA;
    return 16'hFFFE;
  endfunction

  task automatic trial(logic r, logic n, logic i, logic [7:0] sp,
                       logic [15:0] pc, logic [7:0] psr, logic inject);
    int k = winner(r, n, i);
    logic [15:0] vb = vec_base(k);
    logic [7:0] pdata [3];
    pdata[0] = pc[15:8]; pdata[1] = pc[7:0]; pdata[2] = psr;
    for (int v = 0; v < 6; v++) vtab[v] = 8'($urandom);
    @(negedge clk);
    req_reset = r; req_nmi = n; req_irq = i;
    sp_in = sp; pc_in = pc; psr_in = psr;
    @(posedge clk);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c == 0) begin
        req_reset = 0; req_nmi = 0; req_irq = 0;
        check("R2 dummy addr", addr_a, pc);
        check("R2 dummy rw", {15'd0, rw_a}, 16'd1);
      end else if (c <= 3) begin
        check("R3 stack addr", addr_a, {8'h01, 8'(sp - 8'(c - 1))});
        if (k == 3) begin
          check("R6 reset gated read", {15'd0, rw_a}, 16'd1);
          check("R7 variant writes", {15'd0, rw_b}, 16'd0);
          check("R7 variant data", {8'd0, wd_b}, {8'd0, pdata[c-1]});
        end else begin
          check("R5 push write", {15'd0, rw_a}, 16'd0);
          check("R4 push data", {8'd0, wd_a}, {8'd0, pdata[c-1]});
        end
      end else begin
        check("R1 vector addr", addr_a, vb + 16'(c - 4));
        check("R5 vector read", {15'd0, rw_a}, 16'd1);
      end
      if (inject && c == 2) begin
        req_irq = 1; req_nmi = 1; req_reset = (k != 3);
      end
      if (inject && c == 3) begin
        req_reset = 0; req_nmi = 0; req_irq = 0;
      end
    end
    @(negedge clk);
    check("R8 done high", {15'd0, done_a}, 16'd1);
    check("R8 pc_out", pc_out_a, {vtab[vb - 16'hFFFA + 1], vtab[vb - 16'hFFFA]});
    check("R8 sp_out", {8'd0, sp_out_a}, {8'd0, 8'(sp - 8'd3)});
    check("R9 psr_out", {8'd0, psr_out_a}, {8'd0, psr | 8'h04});
    if (k == 3) check("R7 variant done", {15'd0, done_b}, 16'd1);
    @(negedge clk);
    check("R8 done one cycle", {15'd0, done_a}, 16'd0);
    if (inject) check("R10 stays idle", {15'd0, busy_a}, 16'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 busy after reset", {15'd0, busy_a}, 16'd0);
    check("R11 done after reset", {15'd0, done_a}, 16'd0);
    check("R11 rw after reset", {15'd0, rw_a}, 16'd1);

    trial(1, 0, 0, 8'hFD, 16'h1234, 8'h30, 0);
    trial(0, 0, 1, 8'h80, 16'hC0DE, 8'h81, 0);
    trial(0, 1, 0, 8'h40, 16'h8000, 8'h00, 0);
    trial(1, 1, 1, 8'h10, 16'hABCD, 8'hFF, 0);
    trial(0, 1, 1, 8'h01, 16'h0102, 8'h22, 0);
    trial(0, 0, 1, 8'h00, 16'hFFFF, 8'h5A, 1);
    trial(1, 0, 0, 8'h02, 16'h4455, 8'h3C, 1);

    for (int t = 0; t < 60; t++) begin
      logic [2:0] rq = 3'($urandom_range(1, 7));
      trial(rq[2], rq[1], rq[0], 8'($urandom), 16'($urandom), 8'($urandom),
            1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule